// File: doc/BRIEF.md
# CPU Wait-State Injection Logic

This block drives the clock-enable of a 65xx-style CPU core whose bus reaches into the register window of a video display controller. When the enable is low the CPU core must hold all of its state. The block holds it there for one of two reasons.

The first reason is the controller's ready line. While the CPU is in a bus cycle to the controller window and that line is low, the enable stays low. There is no upper limit on how long this lasts. The second reason is a one-cycle penalty on ordinary accesses to the sixteen lowest register offsets of the window.

The penalty is skipped when the access comes from one of the dedicated immediate-store instructions. These instructions write the register select or the data halves directly. The CPU flags them with a separate input.

A one-bit "penalty paid" flag clears the penalty. The flag is set on the first stalled cycle of an access and dropped as soon as the CPU advances. The stall can therefore end even though the address and strobes are frozen while the CPU waits. A read-modify-write instruction is seen as two separate window accesses, so its read phase and its write phase each pay the penalty.

Top module: `cpu_wait_inject`

## Requirements
- R1: While `rstN` is low, `cpuEn` is 1 and `waitActive` is 0. The first low-register access after reset is released pays the full one-cycle penalty.
- R2: When `vdcSel` is 0, `cpuEn` is 1 in the same cycle, whatever the address, `immStore` and `vdcReady`.
- R3: When `vdcSel` is 1 and `vdcReady` is 0, `cpuEn` is 0. This holds for any number of consecutive cycles.
- R4: An access with `vdcSel`=1, `immStore`=0, `vdcReady`=1 and `cpuAddr` < 16 (all bits above bit 3 zero) is stalled for exactly one cycle. `cpuEn` is 0 in its first cycle and 1 in its second.
- R5: An access with `vdcSel`=1, `vdcReady`=1 and `cpuAddr` >= 16 sees `cpuEn`=1 in its first cycle.
- R6: An access with `vdcSel`=1, `immStore`=1 and `vdcReady`=1 sees `cpuEn`=1 in its first cycle, even when `cpuAddr` < 16.
- R7: Two back-to-back accesses to a low register, such as the read and write phases of a read-modify-write, each stall for one cycle. The pattern is 0,1,0,1.
- R8: When a penalised access also finds `vdcReady` low, `cpuEn` stays 0 until `vdcReady` is 1. It then goes to 1 in that same cycle, with no extra penalty cycle.
- R9: `waitActive` is always the inverse of `cpuEn`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | ADDR_W | CPU address offset inside the controller window |
| vdcSel | input | 1 | CPU bus cycle targets the controller window |
| immStore | input | 1 | Access comes from an immediate-store-to-register instruction |
| vdcReady | input | 1 | Controller ready line; low holds the CPU |
| cpuEn | output | 1 | CPU clock-enable; 0 freezes the CPU |
| waitActive | output | 1 | A wait state is being inserted this cycle |

## Verification
On every cycle, the assertions check four things:
- the enable is forced high outside the window and during reset;
- the enable is held low whenever the ready line is low inside the window;
- a fresh penalised access is always stalled;
- an access that was stalled in the previous cycle is released as soon as ready is high, so no second penalty is possible.

Only the bench's scenarios can show the exact one-cycle length of each penalty across the whole address sweep. The same holds for the repeated stall on both phases of a read-modify-write and for the clean restart of the penalty after a reset that lands mid-stall.

// File: rtl/cpu_wait_pkg.sv
package cpu_wait_pkg;
  // Decoded view of the current CPU bus cycle, passed from decode to control.
  typedef struct packed {
    logic penaltyReq; // window access that owes the short register penalty
    logic readyHold;  // window access while the controller is not ready
  } accessDecodeT;
endpackage

// File: rtl/cpu_wait_decode.sv
module cpu_wait_decode
  import cpu_wait_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_SEL_W = 4
) (
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              vdcSel,
  input  logic              immStore,
  input  logic              vdcReady,
  output accessDecodeT      dec
);
  localparam int UPPER_W = ADDR_W - REG_SEL_W;

  logic lowReg;

  generate
    if (UPPER_W > 0) begin : g_upper
      assign lowReg = (cpuAddr[ADDR_W-1:REG_SEL_W] == '0);
    end else begin : g_flat
      // Every address of a window this narrow is a low register.
      logic [ADDR_W-1:0] addrSink;
      assign addrSink = cpuAddr;
      assign lowReg   = 1'b1 | (&addrSink);
    end
  endgenerate

  always_comb begin
    dec.penaltyReq = vdcSel & lowReg & ~immStore;
    dec.readyHold  = vdcSel & ~vdcReady;
  end
endmodule

// File: rtl/cpu_wait_ctrl.sv
module cpu_wait_ctrl
  import cpu_wait_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  accessDecodeT dec,
  output logic         cpuEn,
  output logic         waitActive
);
  logic penaltyPaid;
  logic shortStall;
  logic stall;

  always_comb begin
    shortStall = dec.penaltyReq & ~penaltyPaid;
    stall      = rstN & (shortStall | dec.readyHold);
    cpuEn      = ~stall;
    waitActive = stall;
  end

  // The flag is kept here because the CPU's own state is frozen while it
  // waits and so cannot end the penalty.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      penaltyPaid <= 1'b0;
    end else begin
      penaltyPaid <= stall;
    end
  end
endmodule

// File: rtl/cpu_wait_inject.sv
module cpu_wait_inject
  import cpu_wait_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int REG_SEL_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              vdcSel,
  input  logic              immStore,
  input  logic              vdcReady,
  output logic              cpuEn,
  output logic              waitActive
);
  accessDecodeT dec;

  cpu_wait_decode #(
    .ADDR_W   (ADDR_W),
    .REG_SEL_W(REG_SEL_W)
  ) u_decode (
    .cpuAddr (cpuAddr),
    .vdcSel  (vdcSel),
    .immStore(immStore),
    .vdcReady(vdcReady),
    .dec     (dec)
  );

  cpu_wait_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .dec       (dec),
    .cpuEn     (cpuEn),
    .waitActive(waitActive)
  );
endmodule

// File: rtl/cpu_wait_inject_chk.sv
module cpu_wait_inject_chk #(
  parameter int ADDR_W    = 8,
  parameter int REG_SEL_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] cpuAddr,
  input logic              vdcSel,
  input logic              immStore,
  input logic              vdcReady,
  input logic              cpuEn,
  input logic              waitActive
);
  logic lowHit;
  assign lowHit = vdcSel && !immStore && (cpuAddr < ADDR_W'(1 << REG_SEL_W));

  always_comb begin
    if (!rstN) begin
      AST_RESET_ENABLE: assert (cpuEn && !waitActive); // R1
    end
  end

  AST_IDLE_RUNS: assert property (@(posedge clk) disable iff (!rstN)
    !vdcSel |-> cpuEn); // R2

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (vdcSel && !vdcReady) |-> !cpuEn); // R3

  AST_FRESH_PENALTY: assert property (@(posedge clk) disable iff (!rstN)
    ($past(cpuEn) && lowHit) |-> !cpuEn); // R4

  AST_IMM_NO_PENALTY: assert property (@(posedge clk) disable iff (!rstN)
    (vdcSel && immStore && vdcReady) |-> cpuEn); // R6

  AST_NO_REPEAT_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(cpuEn) && $past(vdcSel) && vdcSel && vdcReady) |-> cpuEn); // R8

  AST_STATUS_MIRROR: assert property (@(posedge clk) disable iff (!rstN)
    waitActive != cpuEn); // R9
endmodule

bind cpu_wait_inject cpu_wait_inject_chk #(
  .ADDR_W   (ADDR_W),
  .REG_SEL_W(REG_SEL_W)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cpuAddr   (cpuAddr),
  .vdcSel    (vdcSel),
  .immStore  (immStore),
  .vdcReady  (vdcReady),
  .cpuEn     (cpuEn),
  .waitActive(waitActive)
);

// File: tb/cpu_wait_inject_tb.sv
module cpu_wait_inject_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int REG_SEL_W  = 4;
  localparam int LOW_LIMIT  = 1 << REG_SEL_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic              vdcSel = 1'b0;
  logic              immStore = 1'b0;
  logic              vdcReady = 1'b1;
  logic              cpuEn;
  logic              waitActive;

  int nChecks = 0;
  int nFails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cpu_wait_inject #(.ADDR_W(ADDR_W), .REG_SEL_W(REG_SEL_W)) u_dut (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .vdcSel(vdcSel),
    .immStore(immStore), .vdcReady(vdcReady), .cpuEn(cpuEn),
    .waitActive(waitActive)
  );

  task automatic checkOut(input string req, input logic expEn);
    nChecks++;
    if (cpuEn !== expEn || waitActive !== !expEn) begin
      nFails++;
      $display("FAIL %s: cpuEn=%b waitActive=%b expected cpuEn=%b waitActive=%b",
               req, cpuEn, waitActive, expEn, !expEn);
    end
  endtask

  // One CPU cycle: drive after the falling edge, sample a moment later.
  task automatic cycle(input logic sel, input int addr, input logic imm,
                       input logic rdy, input string req, input logic expEn);
    @(negedge clk);
    vdcSel   = sel;
    cpuAddr  = ADDR_W'(addr);
    immStore = imm;
    vdcReady = rdy;
    #1;
    checkOut(req, expEn);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    nFails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    // R1: reset state, with a penalised access pending on the bus
    vdcSel = 1'b1; cpuAddr = 3;
    #1; checkOut("R1", 1'b1);
    @(negedge clk); checkOut("R1", 1'b1);
    @(negedge clk); checkOut("R1", 1'b1);
    rstN = 1'b1;
    #1; checkOut("R1", 1'b0);
    cycle(1'b1, 3, 1'b0, 1'b1, "R1", 1'b1);
    cycle(1'b0, 0, 1'b0, 1'b1, "R2", 1'b1);

    // R2: outside the window nothing stalls, whatever the other inputs
    for (int a = 0; a < 32; a++) begin
      cycle(1'b0, a, a[0], a[1], "R2", 1'b1);
    end

    // R4 R5 R6: sweep of every address and both instruction kinds, ready high
    for (int a = 0; a < (1 << ADDR_W); a++) begin
      for (int k = 0; k < 2; k++) begin
        logic owes;
        string req;
        owes = (a < LOW_LIMIT) && (k == 0);
        req = owes ? "R4" : ((k == 1) ? "R6" : "R5");
        if (owes) begin
          cycle(1'b1, a, 1'b0, 1'b1, req, 1'b0);
          cycle(1'b1, a, 1'b0, 1'b1, req, 1'b1);
        end else begin
          cycle(1'b1, a, k[0], 1'b1, req, 1'b1);
        end
        cycle(1'b0, a, 1'b0, 1'b1, "R2", 1'b1);
      end
    end

    // R3 R8: ready held low for several lengths, penalised and not
    for (int n = 1; n <= 6; n++) begin
      for (int k = 0; k < 3; k++) begin
        int addr;
        logic imm;
        addr = (k == 2) ? 40 : n;
        imm  = (k == 1);
        for (int w = 0; w < n; w++) begin
          cycle(1'b1, addr, imm, 1'b0, "R3", 1'b0);
        end
        cycle(1'b1, addr, imm, 1'b1, "R8", 1'b1);
        cycle(1'b0, 0, 1'b0, 1'b1, "R2", 1'b1);
      end
    end

    // R7: read then write phase of a read-modify-write on register 3
    cycle(1'b1, 3, 1'b0, 1'b1, "R7", 1'b0);
    cycle(1'b1, 3, 1'b0, 1'b1, "R7", 1'b1);
    cycle(1'b1, 3, 1'b0, 1'b1, "R7", 1'b0);
    cycle(1'b1, 3, 1'b0, 1'b1, "R7", 1'b1);
    // R7: the same with a ready wait on the write phase
    cycle(1'b1, 15, 1'b0, 1'b1, "R7", 1'b0);
    cycle(1'b1, 15, 1'b0, 1'b1, "R7", 1'b1);
    cycle(1'b1, 15, 1'b0, 1'b0, "R7", 1'b0);
    cycle(1'b1, 15, 1'b0, 1'b0, "R7", 1'b0);
    cycle(1'b1, 15, 1'b0, 1'b1, "R7", 1'b1);
    cycle(1'b0, 0, 1'b0, 1'b1, "R2", 1'b1);

    // R1: reset landing mid-stall, then the penalty starts again
    cycle(1'b1, 7, 1'b0, 1'b0, "R3", 1'b0);
    @(negedge clk); rstN = 1'b0; #1; checkOut("R1", 1'b1);
    @(negedge clk); vdcReady = 1'b1; #1; checkOut("R1", 1'b1);
    rstN = 1'b1; #1; checkOut("R1", 1'b0);
    cycle(1'b1, 7, 1'b0, 1'b1, "R1", 1'b1);
    cycle(1'b0, 0, 1'b0, 1'b1, "R9", 1'b1);

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule